// File: doc/BRIEF.md
# SD Card Command Channel Engine

This block issues a single command on the command wire of an SD card and gathers the card's answer. Software first loads a 32-bit argument. It then writes a command word holding a 6-bit command index and four option flags, and that write starts the exchange. The engine serializes a 48-bit frame that carries its own CRC7. It then waits for the card's reply and checks it. Depending on the flags, the reply is a 48-bit short response, a 136-bit long response, or no response at all.

Every bit step advances only on a one-cycle pulse from an external SD clock divider, so the same logic serves slow identification clocks and fast transfer clocks alike. Status outputs tell software three things: whether a command is in flight, whether the last command failed, and whether the card is holding its DAT0 line low to signal it is busy.

Top module: `sdcmd_engine`

## Requirements
- R1: A write to the command word while idle starts a command, and busy reads 1 from the next clock. The frame uses the argument held by the last argument write.
- R2: The frame is 48 bits, sent MSB first with one bit per tick pulse, in this order: 0, 1, the 6-bit index, the 32-bit argument, the CRC7 (x^7+x^3+1) over the first 40 bits, then 1. The drive enable is high only while the frame is being sent, and the line reads 1 whenever it is not driven.
- R3: Command word bits [5:0] are the index. Bit 6 means no reply, bit 7 long reply, bit 8 ignore the CRC, and bit 9 skip the index check. With bit 6 set, busy falls right after the 48th bit and error stays 0.
- R4: For a short reply, rsp0 receives bits [39:8] of the 48-bit reply.
- R5: For a long reply, the four response words receive bits [127:0] of the 136-bit reply, with rsp3 the most significant.
- R6: If no start bit (0) is seen within RSP_TIMEOUT ticks (default 64) after the frame, busy falls and error is set.
- R7: A CRC7 mismatch in the reply sets error, unless bit 8 was set. A short reply's CRC covers reply bits [47:8], and a long reply's CRC covers bits [127:8].
- R8: An end bit of 0 in the reply sets error.
- R9: For a short reply, an index field (bits [45:40]) that differs from the sent index sets error, unless bit 9 was set.
- R10: A command word written while busy is ignored, and it starts no frame.
- R11: card_busy reads the inverse of dat0_in, delayed by DAT0_SYNC clocks (default 2).
- R12: Error is cleared when a command starts. Error and the response words change only when a command completes. A timed-out command leaves the response words untouched.
- R13: With no tick pulse, the line and the bit position hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sd_tick | input | 1 | One-cycle bit-step pulse from the divider |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command word write strobe, starts a command |
| cmd_wdata | input | 10 | Index and option flags |
| cmd_out | output | 1 | Command wire output value |
| cmd_oe | output | 1 | Command wire drive enable |
| cmd_in | input | 1 | Command wire input value |
| dat0_in | input | 1 | DAT0 line from the card |
| busy | output | 1 | Command in flight |
| error | output | 1 | Last command failed |
| card_busy | output | 1 | Card holds DAT0 low |
| rsp0 | output | 32 | Response word, least significant |
| rsp1 | output | 32 | Response word |
| rsp2 | output | 32 | Response word |
| rsp3 | output | 32 | Response word, most significant |

## Verification
The assertions check several properties on every cycle. The command wire is driven only while busy, and it is released high otherwise. A command begins only after a command-word write. The line value moves only on a tick. Error and the response words stay frozen between commands. Frame content and CRC values, response capture positions, the timeout boundary, and the flag-dependent error decisions all depend on specific reply bit patterns, so only the bench scenarios can show them.

// File: rtl/sdce_pkg.sv
package sdce_pkg;
   localparam int IDX_W      = 6;
   localparam int ARG_W      = 32;
   localparam int CRC_W      = 7;
   localparam int HEAD_W     = 2 + IDX_W + ARG_W;
   localparam int FRAME_W    = HEAD_W + CRC_W + 1;
   localparam int LONG_W     = 136;
   localparam int KEEP_W     = 128;
   localparam int CMD_WORD_W = IDX_W + 4;

   typedef struct packed {
      logic             skip_idx;
      logic             no_crc;
      logic             long_rsp;
      logic             no_rsp;
      logic [IDX_W-1:0] index;
   } cmd_word_t;

   function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb = b ^ c[CRC_W-1];
      return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
   endfunction

   function automatic logic [CRC_W-1:0] crc7_head(input logic [HEAD_W-1:0] d);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int i = HEAD_W - 1; i >= 0; i--) c = crc7_step(c, d[i]);
      return c;
   endfunction
endpackage

// File: rtl/sdce_tx.sv
module sdce_tx #(
   parameter int BITS = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            load,
   input  logic [BITS-1:0] frame,
   output logic            line_out,
   output logic            drive,
   output logic            done
);
   localparam int CNT_W = $clog2(BITS);

   logic [BITS-1:0]  shreg;
   logic [CNT_W-1:0] cnt;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '1;
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            shreg  <= frame;
            cnt    <= '0;
            active <= 1'b1;
         end else if (active && tick) begin
            shreg <= {shreg[BITS-2:0], 1'b1};
            if (cnt == CNT_W'(BITS - 1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign line_out = active ? shreg[BITS-1] : 1'b1;
   assign drive    = active;
endmodule

// File: rtl/sdce_rx.sv
module sdce_rx #(
   parameter int TIMEOUT = 64,
   parameter int SHORT_W = 48,
   parameter int LONG_W  = 136,
   parameter int KEEP_W  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              long_sel,
   input  logic              line_in,
   output logic              done,
   output logic              no_start,
   output logic              crc_bad,
   output logic              end_bad,
   output logic [KEEP_W-1:0] data
);
   import sdce_pkg::*;

   localparam int WC_W      = $clog2(TIMEOUT);
   localparam int RC_W      = $clog2(LONG_W);
   localparam int SHORT_END = SHORT_W - 8;
   localparam int LONG_BEG  = 8;
   localparam int LONG_END  = LONG_W - 8;

   typedef enum logic [1:0] {R_OFF, R_WAIT, R_DATA} rx_state_t;

   rx_state_t        st;
   logic [WC_W-1:0]  wcnt;
   logic [RC_W-1:0]  rcnt;
   logic [RC_W-1:0]  last;
   logic [CRC_W-1:0] crc;
   logic             long_q;
   logic             crc_take;

   assign last     = long_q ? RC_W'(LONG_W - 1) : RC_W'(SHORT_W - 1);
   assign crc_take = long_q ? (rcnt >= RC_W'(LONG_BEG) && rcnt < RC_W'(LONG_END))
                            : (rcnt < RC_W'(SHORT_END));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= R_OFF;
         wcnt     <= '0;
         rcnt     <= '0;
         crc      <= '0;
         long_q   <= 1'b0;
         done     <= 1'b0;
         no_start <= 1'b0;
         crc_bad  <= 1'b0;
         end_bad  <= 1'b0;
         data     <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            R_OFF: if (start) begin
               st       <= R_WAIT;
               wcnt     <= '0;
               long_q   <= long_sel;
               no_start <= 1'b0;
               crc_bad  <= 1'b0;
               end_bad  <= 1'b0;
            end
            R_WAIT: if (tick) begin
               if (!line_in) begin
                  st   <= R_DATA;
                  rcnt <= RC_W'(1);
                  data <= {data[KEEP_W-2:0], 1'b0};
                  crc  <= long_q ? '0 : crc7_step('0, 1'b0);
               end else if (wcnt == WC_W'(TIMEOUT - 1)) begin
                  st       <= R_OFF;
                  done     <= 1'b1;
                  no_start <= 1'b1;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            R_DATA: if (tick) begin
               data <= {data[KEEP_W-2:0], line_in};
               if (crc_take) crc <= crc7_step(crc, line_in);
               if (rcnt == last) begin
                  st      <= R_OFF;
                  done    <= 1'b1;
                  crc_bad <= (crc != data[CRC_W-1:0]);
                  end_bad <= !line_in;
               end else begin
                  rcnt <= rcnt + 1'b1;
               end
            end
            default: st <= R_OFF;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
   parameter int RSP_TIMEOUT = 64,
   parameter int DAT0_SYNC   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sd_tick,
   input  logic        arg_we,
   input  logic [31:0] arg_wdata,
   input  logic        cmd_we,
   input  logic [9:0]  cmd_wdata,
   output logic        cmd_out,
   output logic        cmd_oe,
   input  logic        cmd_in,
   input  logic        dat0_in,
   output logic        busy,
   output logic        error,
   output logic        card_busy,
   output logic [31:0] rsp0,
   output logic [31:0] rsp1,
   output logic [31:0] rsp2,
   output logic [31:0] rsp3
);
   import sdce_pkg::*;

   if (RSP_TIMEOUT < 2) begin : g_bad_timeout
      $error("RSP_TIMEOUT must be at least 2");
   end
   if (DAT0_SYNC < 1) begin : g_bad_sync
      $error("DAT0_SYNC must be at least 1");
   end

   typedef enum logic [1:0] {E_IDLE, E_TX, E_RX} eng_state_t;

   eng_state_t            state;
   logic [ARG_W-1:0]      arg_q;
   cmd_word_t             cmd_q;
   cmd_word_t             cmd_new;
   logic                  err_q;
   logic [3:0][31:0]      rsp_q;
   logic [HEAD_W-1:0]     head;
   logic [FRAME_W-1:0]    frame;
   logic                  tx_load, tx_done;
   logic                  rx_start, rx_done, rx_no_start, rx_crc_bad, rx_end_bad;
   logic [KEEP_W-1:0]     rx_data;
   logic                  rsp_err;

   assign cmd_new  = cmd_word_t'(cmd_wdata);
   assign head     = {2'b01, cmd_new.index, arg_q};
   assign frame    = {head, crc7_head(head), 1'b1};
   assign tx_load  = (state == E_IDLE) && cmd_we;
   assign rx_start = (state == E_TX) && tx_done && !cmd_q.no_rsp;

   assign rsp_err = rx_no_start | rx_end_bad
                  | (rx_crc_bad & ~cmd_q.no_crc)
                  | (~cmd_q.long_rsp & ~cmd_q.skip_idx & (rx_data[45:40] != cmd_q.index));

   sdce_tx #(.BITS(FRAME_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(sd_tick), .load(tx_load), .frame(frame),
      .line_out(cmd_out), .drive(cmd_oe), .done(tx_done)
   );

   sdce_rx #(.TIMEOUT(RSP_TIMEOUT), .SHORT_W(FRAME_W), .LONG_W(LONG_W), .KEEP_W(KEEP_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(sd_tick), .start(rx_start), .long_sel(cmd_q.long_rsp),
      .line_in(cmd_in), .done(rx_done), .no_start(rx_no_start), .crc_bad(rx_crc_bad),
      .end_bad(rx_end_bad), .data(rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= E_IDLE;
         arg_q <= '0;
         cmd_q <= '0;
         err_q <= 1'b0;
         rsp_q <= '0;
      end else begin
         if (arg_we) arg_q <= arg_wdata;
         case (state)
            E_IDLE: if (cmd_we) begin
               cmd_q <= cmd_new;
               err_q <= 1'b0;
               state <= E_TX;
            end
            E_TX: if (tx_done) state <= cmd_q.no_rsp ? E_IDLE : E_RX;
            E_RX: if (rx_done) begin
               state <= E_IDLE;
               err_q <= rsp_err;
               if (!rx_no_start) begin
                  if (cmd_q.long_rsp) rsp_q <= rx_data;
                  else                rsp_q[0] <= rx_data[39:8];
               end
            end
            default: state <= E_IDLE;
         endcase
      end
   end

   logic [DAT0_SYNC-1:0] dsync;
   for (genvar i = 0; i < DAT0_SYNC; i++) begin : g_dsync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dsync[i] <= 1'b1;
         else if (i == 0) dsync[i] <= dat0_in;
         else             dsync[i] <= dsync[(i == 0) ? 0 : i - 1];
      end
   end

   assign card_busy = ~dsync[DAT0_SYNC-1];
   assign busy      = (state != E_IDLE);
   assign error     = err_q;
   assign rsp0      = rsp_q[0];
   assign rsp1      = rsp_q[1];
   assign rsp2      = rsp_q[2];
   assign rsp3      = rsp_q[3];
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sd_tick,
   input logic        cmd_we,
   input logic        cmd_out,
   input logic        cmd_oe,
   input logic        busy,
   input logic        error,
   input logic [31:0] rsp0,
   input logic [31:0] rsp1,
   input logic [31:0] rsp2,
   input logic [31:0] rsp3
);
   p_drive_in_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);

   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_oe |-> cmd_out);

   p_start_by_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_we));

   p_bit_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_oe && $past(cmd_oe) && !$past(sd_tick)) |-> $stable(cmd_out));

   p_error_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(error));

   p_rsp_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable({rsp3, rsp2, rsp1, rsp0}));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (.*);

// File: tb/sdcmd_engine_tb.sv
`timescale 1ns/1ps
module sdcmd_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sd_tick = 1'b0;
   logic        arg_we = 1'b0;
   logic [31:0] arg_wdata = '0;
   logic        cmd_we = 1'b0;
   logic [9:0]  cmd_wdata = '0;
   logic        cmd_in = 1'b1;
   logic        dat0_in = 1'b1;
   logic        cmd_out, cmd_oe, busy, error, card_busy;
   logic [31:0] rsp0, rsp1, rsp2, rsp3;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   sdcmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .arg_we(arg_we), .arg_wdata(arg_wdata),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
      .cmd_in(cmd_in), .dat0_in(dat0_in), .busy(busy), .error(error), .card_busy(card_busy),
      .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] tb_crc(input logic [119:0] d, input int n);
      logic [6:0] r;
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic top;
         top = r[6] ^ d[i];
         r = {r[5:0], 1'b0};
         if (top) r = r ^ 7'h09;
      end
      return r;
   endfunction

   function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] pay,
                                            input bit bad_crc, input bit bad_end);
      logic [39:0] h;
      logic [6:0]  c;
      h = {2'b00, idx, pay};
      c = tb_crc({80'b0, h}, 40);
      if (bad_crc) c = c ^ 7'h01;
      return {h, c, ~bad_end};
   endfunction

   function automatic logic [47:0] mk_frame(input logic [5:0] idx, input logic [31:0] a);
      logic [39:0] h;
      h = {2'b01, idx, a};
      return {h, tb_crc({80'b0, h}, 40), 1'b1};
   endfunction

   task automatic write_arg(input logic [31:0] a);
      @(negedge clk); arg_we = 1'b1; arg_wdata = a;
      @(negedge clk); arg_we = 1'b0;
   endtask

   task automatic write_cmd(input logic [9:0] w);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic sd_bit(input logic din, output logic dout);
      @(negedge clk);
      dout = cmd_out;
      cmd_in = din;
      sd_tick = 1'b1;
      @(negedge clk);
      sd_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic grab_frame(output logic [47:0] f, output logic oe_ok);
      oe_ok = 1'b1;
      for (int i = 47; i >= 0; i--) begin
         logic b;
         @(negedge clk);
         if (!cmd_oe) oe_ok = 1'b0;
         sd_bit(1'b1, b);
         f[i] = b;
      end
   endtask

   task automatic send_rsp(input logic [135:0] r, input int len, input int gap);
      logic d;
      for (int i = 0; i < gap; i++) sd_bit(1'b1, d);
      for (int i = len - 1; i >= 0; i--) sd_bit(r[i], d);
      cmd_in = 1'b1;
   endtask

   task automatic t_reset;
      chk("R2 reset line high", cmd_out, 1);
      chk("R2 reset not driving", cmd_oe, 0);
      chk("R1 reset idle", busy, 0);
      chk("R12 reset error", error, 0);
      chk("R4 reset rsp", {rsp3, rsp2, rsp1, rsp0}, 0);
      chk("R11 reset card_busy", card_busy, 0);
   endtask

   task automatic t_skip_and_gate;
      logic [47:0] f;
      logic ok;
      write_arg(32'h0);
      write_cmd(10'h040);
      chk("R1 busy after write", busy, 1);
      repeat (10) @(negedge clk);
      chk("R13 no tick holds start bit", cmd_out, 0);
      chk("R13 no tick still driving", cmd_oe, 1);
      grab_frame(f, ok);
      chk("R2 frame CMD0", f, 48'h400000000095);
      chk("R2 oe during frame", ok, 1);
      chk("R3 no-reply finishes", busy, 0);
      chk("R3 no-reply no error", error, 0);
      chk("R2 released after frame", cmd_oe, 0);
   endtask

   task automatic t_short;
      logic [47:0] f;
      logic ok;
      write_arg(32'h000001AA);
      write_cmd(10'h008);
      grab_frame(f, ok);
      chk("R2 frame CMD8", f, 48'h48000001AA87);
      write_cmd(10'h040);
      send_rsp({88'b0, mk_short(6'd8, 32'h000001AA, 0, 0)}, 48, 2);
      chk("R4 short done", busy, 0);
      chk("R4 short no error", error, 0);
      chk("R4 short payload", rsp0, 32'h000001AA);
      repeat (6) @(negedge clk);
      chk("R10 write while busy ignored", busy, 0);
      chk("R10 no second frame", cmd_oe, 0);
   endtask

   task automatic t_long;
      logic [47:0]  f;
      logic         ok;
      logic [119:0] d;
      logic [6:0]   c;
      d = 120'h0123456789ABCDEF_FEDCBA98765432;
      c = tb_crc(d, 120);
      write_arg(32'h0);
      write_cmd(10'h282);
      grab_frame(f, ok);
      chk("R2 frame CMD2", f, mk_frame(6'd2, 32'h0));
      send_rsp({8'h3F, d, c, 1'b1}, 136, 3);
      chk("R5 long no error", error, 0);
      chk("R5 long words", {rsp3, rsp2, rsp1, rsp0}, {d, c, 1'b1});
      chk("R5 rsp3 top word", rsp3, d[119:88]);
   endtask

   task automatic t_crc;
      logic [47:0] f;
      logic ok;
      write_arg(32'h00001234);
      write_cmd(10'h011);
      grab_frame(f, ok);
      chk("R2 frame CMD17", f, mk_frame(6'd17, 32'h00001234));
      send_rsp({88'b0, mk_short(6'd17, 32'hCAFE0001, 1, 0)}, 48, 2);
      chk("R7 crc mismatch error", error, 1);
      write_cmd(10'h111);
      grab_frame(f, ok);
      send_rsp({88'b0, mk_short(6'd17, 32'hCAFE0002, 1, 0)}, 48, 2);
      chk("R7 ignore crc no error", error, 0);
      chk("R7 ignore crc payload", rsp0, 32'hCAFE0002);
   endtask

   task automatic t_end;
      logic [47:0] f;
      logic ok;
      write_cmd(10'h00D);
      grab_frame(f, ok);
      send_rsp({88'b0, mk_short(6'd13, 32'h00000900, 0, 1)}, 48, 2);
      chk("R8 bad end bit error", error, 1);
   endtask

   task automatic t_index;
      logic [47:0] f;
      logic ok;
      write_cmd(10'h003);
      grab_frame(f, ok);
      send_rsp({88'b0, mk_short(6'd5, 32'h11112222, 0, 0)}, 48, 2);
      chk("R9 index mismatch error", error, 1);
      write_cmd(10'h203);
      grab_frame(f, ok);
      send_rsp({88'b0, mk_short(6'h3F, 32'h80FF8000, 0, 0)}, 48, 4);
      chk("R9 index check skipped", error, 0);
      chk("R9 payload kept", rsp0, 32'h80FF8000);
   endtask

   task automatic t_timeout;
      logic [47:0] f;
      logic ok;
      logic d;
      write_cmd(10'h005);
      grab_frame(f, ok);
      for (int i = 0; i < 63; i++) sd_bit(1'b1, d);
      chk("R6 still waiting at 63", busy, 1);
      sd_bit(1'b1, d);
      chk("R6 timeout ends", busy, 0);
      chk("R6 timeout error", error, 1);
      chk("R12 rsp unchanged on timeout", rsp0, 32'h80FF8000);
      write_cmd(10'h040);
      chk("R12 error cleared at start", error, 0);
      grab_frame(f, ok);
      chk("R12 next command ends", busy, 0);
   endtask

   task automatic t_card_busy;
      @(negedge clk); dat0_in = 1'b0;
      @(negedge clk);
      chk("R11 sync delay", card_busy, 0);
      @(negedge clk);
      chk("R11 card busy", card_busy, 1);
      dat0_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 card released", card_busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_skip_and_gate();
      t_short();
      t_long();
      t_crc();
      t_end();
      t_index();
      t_timeout();
      t_card_busy();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule